// File: doc/BRIEF.md
# Raster Position Timer with Vertical-Blank NMI and Position IRQ

This block keeps the beam position of a video frame. A horizontal counter advances two master cycles on every enabled `step` and a line counter advances at each line end. The timing follows a 60 Hz or a 50 Hz scheme. The length of one particular line changes with frame parity and interlace, and the number of lines in a frame changes the same way. When the frame reaches its blanking line, the block enters vertical blank, sets an NMI flag and, if NMI is enabled, emits a one-cycle NMI pulse. A programmable horizontal/vertical compare raises an interrupt level on the rising edge of its match condition.

The processor programs the block through a byte-wide write port: a control byte and two 9-bit compare targets, each split into a low and a high byte. It reads three things back: the NMI flag, the IRQ flag and a status byte. Reading either flag clears it. The raw position, the blanking level and both interrupt outputs are also brought out as ports for neighbouring logic.

Top module: `raster_irq_timer`

## Requirements
- R1: After reset, and on every cycle with `step` high, `hpos` rises by 2. At a line end `hpos` returns to 0 and `vpos` moves to the next line. With `step` low, nothing changes.
- R2: A line ends when `hpos` would reach LINE_LEN (nominal 1364). Two exceptions apply. With `pal_mode`=0, line 240 ends at LINE_LEN-LINE_ADJ when `interlace`=0 and `even_frame`=0. With `pal_mode`=1, line 311 ends at LINE_LEN+LINE_ADJ when `interlace`=1 and `even_frame`=0. LINE_ADJ defaults to 4.
- R3: With `pal_mode`=0 the last line of a frame is 261, or 262 when `interlace`=1 and `even_frame`=1. With `pal_mode`=1 the last line is 311, or 312 under the same condition. After the last line, `vpos` goes to 0.
- R4: `vblank` rises on entry to line 225 when `overscan`=0, and on entry to line 240 otherwise. Entering line 0 clears `vblank` and the NMI flag. Vertical-blank entry sets the NMI flag.
- R5: At vertical-blank entry with NMI enabled (control bit 7), `nmi_pulse` is high for exactly one cycle. Reading the NMI flag (`rd_sel`=0) returns the flag in bit 7 and the constant 2 in bits 3:0. The read then clears the flag.
- R6: Writing control bit 7 = 1 while NMI is disabled and the flag is set produces an `nmi_pulse` in the next cycle. With NMI disabled, vertical-blank entry produces no pulse.
- R7: The IRQ condition is (H enable bit 4 or V enable bit 5) and (`vpos` = V target or V disabled) and (`hpos` = 4 × H target or H disabled). It is evaluated before the position moves. `irq` rises one cycle after the first stepped cycle in which the condition holds. It does not fire again while the condition stays true.
- R8: Reading the IRQ flag (`rd_sel`=1) returns `irq` in bit 7 and drops `irq` on the next cycle. A control write with bits 5 and 4 both 0 also drops `irq`.
- R9: The status read (`rd_sel`=2) has `vblank` in bit 7. Bit 6 is 1 when `hpos` < 4 or `hpos` >= HBL_START (default 1096). All other bits are 0.
- R10: Reset gives `hpos`=0, `vpos`=0, `vblank`, `irq` and `nmi_pulse` all 0, both enables off, and both targets 0x1FF. The target bytes are written with `wr_sel` 1 (H low), 2 (H bit 8), 3 (V low) and 4 (V bit 8). A low-byte write keeps bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance the position by one 2-cycle step |
| pal_mode | input | 1 | 1 selects 50 Hz frame timing |
| interlace | input | 1 | Interlaced frame |
| even_frame | input | 1 | Current frame is the even field |
| overscan | input | 1 | Delay vertical blank to line 240 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 control, 1-4 target bytes |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (clears the selected flag) |
| rd_sel | input | 2 | Read source: 0 NMI, 1 IRQ, 2 status |
| rd_data | output | 8 | Read data, combinational from rd_sel |
| hpos | output | 11 | Horizontal position in master cycles |
| vpos | output | 9 | Line number |
| vblank | output | 1 | Vertical blank level |
| nmi_pulse | output | 1 | One-cycle NMI request |
| irq | output | 1 | IRQ level held until acknowledged |

## Verification
The position moves on the edge of each stepped cycle, so the bench samples `hpos`, `vpos` and `vblank` at the falling edge and counts one sample per step. It derives line lengths, last lines and the blanking line from those sample counts. `nmi_pulse` and the vertical-blank flag rise on the same edge that brings `vpos` to the blanking line, so the bench checks them at the first falling edge that shows that line. `irq` rises one edge later than the match, so the bench checks it as low on the matching sample and high on the next. `rd_data` is combinational and is read in the same cycle as the strobe. The clears caused by reads and writes are checked at the falling edge after the strobe's clock edge.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic [2:0] {
        WR_CTRL    = 3'd0,
        WR_HTGT_LO = 3'd1,
        WR_HTGT_HI = 3'd2,
        WR_VTGT_LO = 3'd3,
        WR_VTGT_HI = 3'd4
    } wr_sel_e;

    typedef enum logic [1:0] {
        RD_NMI  = 2'd0,
        RD_IRQ  = 2'd1,
        RD_STAT = 2'd2,
        RD_NONE = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic nmi_en;
        logic v_en;
        logic h_en;
    } ctrl_t;

    typedef struct packed {
        logic vbl_start;
        logic vbl_end;
    } frame_evt_t;

    localparam int CTRL_NMI_BIT = 7;
    localparam int CTRL_VEN_BIT = 5;
    localparam int CTRL_HEN_BIT = 4;
    localparam logic [3:0] VERSION_ID = 4'h2;
    localparam int H_SCALE_SH = 2;

    // End position of the current line in master cycles.
    function automatic int unsigned line_end_len(
        input logic        pal,
        input logic        il,
        input logic        even,
        input int unsigned line,
        input int unsigned nominal,
        input int unsigned adj,
        input int unsigned short_line,
        input int unsigned long_line
    );
        if (!pal && !il && !even && line == short_line) return nominal - adj;
        if (pal && il && !even && line == long_line)    return nominal + adj;
        return nominal;
    endfunction

    // True when next_line is one past the last line of the frame.
    function automatic logic frame_done(
        input logic        pal,
        input logic        il,
        input logic        even,
        input int unsigned next_line,
        input int unsigned ntsc_lines,
        input int unsigned pal_lines
    );
        int unsigned base;
        base = pal ? pal_lines : ntsc_lines;
        return (next_line == base && (!il || !even)) || (next_line == base + 1);
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int HW = 11,
    parameter int VW = 9,
    parameter int unsigned LINE_LEN        = 1364,
    parameter int unsigned LINE_ADJ        = 4,
    parameter int unsigned NTSC_SHORT_LINE = 240,
    parameter int unsigned PAL_LONG_LINE   = 311,
    parameter int unsigned NTSC_LINES      = 262,
    parameter int unsigned PAL_LINES       = 312,
    parameter int unsigned VBL_LINE        = 225,
    parameter int unsigned VBL_OVS_LINE    = 240
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          pal_mode,
    input  logic          interlace,
    input  logic          even_frame,
    input  logic          overscan,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos,
    output logic          vblank,
    output frame_evt_t    evt
);

    localparam logic [HW-1:0] H_STEP   = HW'(2);
    localparam logic [HW-1:0] H_BOUND  = HW'(LINE_LEN + LINE_ADJ);
    localparam logic [VW-1:0] V_VBL    = VW'(VBL_LINE);
    localparam logic [VW-1:0] V_VBLOVS = VW'(VBL_OVS_LINE);
    localparam logic [VW-1:0] V_MAX    = VW'(PAL_LINES);

    logic [HW-1:0] cur_end;
    logic [HW-1:0] h_inc;
    logic [VW-1:0] v_inc;
    logic [VW-1:0] v_new;
    logic          eol;
    logic          wrap;

    always_comb begin
        cur_end = HW'(line_end_len(pal_mode, interlace, even_frame, 32'(vpos),
                                   LINE_LEN, LINE_ADJ, NTSC_SHORT_LINE, PAL_LONG_LINE));
        h_inc   = hpos + H_STEP;
        eol     = (h_inc >= cur_end);
        v_inc   = vpos + VW'(1);
        wrap    = frame_done(pal_mode, interlace, even_frame, 32'(v_inc),
                             NTSC_LINES, PAL_LINES);
        v_new   = wrap ? '0 : v_inc;
        evt.vbl_end   = step && eol && wrap;
        evt.vbl_start = step && eol && !wrap &&
                        ((v_new == V_VBL && !overscan) ||
                         (v_new == V_VBLOVS && !vblank));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos   <= '0;
            vpos   <= '0;
            vblank <= 1'b0;
        end else if (step) begin
            if (eol) begin
                hpos <= '0;
                vpos <= v_new;
                if (evt.vbl_end)        vblank <= 1'b0;
                else if (evt.vbl_start) vblank <= 1'b1;
            end else begin
                hpos <= h_inc;
            end
        end
    end

    // R1: a step either advances by two or restarts the line
    assert_hpos_step_R1: assert property (@(posedge clk) disable iff (rst)
        step |=> (hpos == $past(hpos) + H_STEP) || (hpos == '0));

    // R2: position never passes the longest line
    assert_hpos_bound_R2: assert property (@(posedge clk) disable iff (rst)
        hpos < H_BOUND);

    // R3: line counter stays inside the longest frame
    assert_vpos_bound_R3: assert property (@(posedge clk) disable iff (rst)
        vpos <= V_MAX);

    // R4: line-0 entry leaves blanking
    assert_vbl_end_R4: assert property (@(posedge clk) disable iff (rst)
        evt.vbl_end |=> (!vblank && vpos == '0));

endmodule

// File: rtl/raster_irq_cmp.sv
module raster_irq_cmp
    import raster_pkg::*;
#(
    parameter int HW = 11,
    parameter int VW = 9,
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [HW-1:0] hpos,
    input  logic [VW-1:0] vpos,
    input  ctrl_t         ctrl,
    input  logic [TW-1:0] htgt,
    input  logic [TW-1:0] vtgt,
    output logic          hit
);

    logic h_match;
    logic v_match;
    logic cond;
    logic cond_q;

    always_comb begin
        h_match = (hpos == HW'({htgt, {H_SCALE_SH{1'b0}}}));
        v_match = (vpos == VW'(vtgt));
        cond    = (ctrl.h_en || ctrl.v_en) &&
                  (v_match || !ctrl.v_en) &&
                  (h_match || !ctrl.h_en);
        hit     = step && cond && !cond_q;
    end

    always_ff @(posedge clk) begin
        if (rst)       cond_q <= 1'b0;
        else if (step) cond_q <= cond;
    end

    // R7: a hit is a rising edge, so the next stepped cycle cannot hit again
    assert_irq_edge_R7: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

endmodule

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
#(
    parameter int HW = 11,
    parameter int TW = 9,
    parameter int DW = 8,
    parameter int unsigned HBL_START = 1096,
    parameter int unsigned HBL_END   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  wr_sel_e       wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  rd_sel_e       rd_sel,
    input  logic [HW-1:0] hpos,
    input  logic          vblank,
    input  frame_evt_t    evt,
    input  logic          irq_hit,
    output ctrl_t         ctrl,
    output logic [TW-1:0] htgt,
    output logic [TW-1:0] vtgt,
    output logic          nmi_pulse,
    output logic          irq,
    output logic [DW-1:0] rd_data
);

    localparam int HI_W = TW - DW;

    logic  nmi_flag;
    logic  hblank;
    logic  wr_ctrl;
    logic  irq_drop;
    logic  irq_ack;
    logic  nmi_ack;
    logic  reenable;
    ctrl_t ctrl_new;

    always_comb begin
        hblank   = (hpos < HW'(HBL_END)) || (hpos >= HW'(HBL_START));
        wr_ctrl  = wr_en && (wr_sel == WR_CTRL);
        ctrl_new = '{nmi_en: wr_data[CTRL_NMI_BIT],
                     v_en:   wr_data[CTRL_VEN_BIT],
                     h_en:   wr_data[CTRL_HEN_BIT]};
        irq_drop = wr_ctrl && !ctrl_new.v_en && !ctrl_new.h_en;
        irq_ack  = rd_en && (rd_sel == RD_IRQ);
        nmi_ack  = rd_en && (rd_sel == RD_NMI);
        reenable = wr_ctrl && ctrl_new.nmi_en && !ctrl.nmi_en && nmi_flag;
        unique case (rd_sel)
            RD_NMI:  rd_data = {nmi_flag, 3'b000, VERSION_ID};
            RD_IRQ:  rd_data = {irq, 7'b0};
            RD_STAT: rd_data = {vblank, hblank, 6'b0};
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            htgt <= '1;
            vtgt <= '1;
        end else if (wr_en) begin
            unique case (wr_sel)
                WR_CTRL:    ctrl <= ctrl_new;
                WR_HTGT_LO: htgt[DW-1:0]  <= wr_data;
                WR_HTGT_HI: htgt[TW-1:DW] <= wr_data[HI_W-1:0];
                WR_VTGT_LO: vtgt[DW-1:0]  <= wr_data;
                WR_VTGT_HI: vtgt[TW-1:DW] <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_flag  <= 1'b0;
            nmi_pulse <= 1'b0;
        end else begin
            nmi_pulse <= reenable || (evt.vbl_start && ctrl.nmi_en);
            if (evt.vbl_start)              nmi_flag <= 1'b1;
            else if (evt.vbl_end || nmi_ack) nmi_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      irq <= 1'b0;
        else if (irq_hit)             irq <= 1'b1;
        else if (irq_ack || irq_drop) irq <= 1'b0;
    end

    // R4: entering blanking sets the NMI flag
    assert_vbl_flag_R4: assert property (@(posedge clk) disable iff (rst)
        evt.vbl_start |=> nmi_flag);

    // R6: enabling NMI with the flag pending raises a pulse
    assert_nmi_reenable_R6: assert property (@(posedge clk) disable iff (rst)
        reenable |=> nmi_pulse);

    // R8: reading the IRQ flag acknowledges it
    assert_irq_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_hit) |=> !irq);

    // R8: turning off both position enables drops the IRQ
    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_drop && !irq_hit) |=> !irq);

endmodule

// File: rtl/raster_irq_timer.sv
module raster_irq_timer
    import raster_pkg::*;
#(
    parameter int HW = 11,
    parameter int VW = 9,
    parameter int TW = 9,
    parameter int DW = 8,
    parameter int unsigned LINE_LEN        = 1364,
    parameter int unsigned LINE_ADJ        = 4,
    parameter int unsigned NTSC_SHORT_LINE = 240,
    parameter int unsigned PAL_LONG_LINE   = 311,
    parameter int unsigned NTSC_LINES      = 262,
    parameter int unsigned PAL_LINES       = 312,
    parameter int unsigned VBL_LINE        = 225,
    parameter int unsigned VBL_OVS_LINE    = 240,
    parameter int unsigned HBL_START       = 1096,
    parameter int unsigned HBL_END         = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          pal_mode,
    input  logic          interlace,
    input  logic          even_frame,
    input  logic          overscan,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [1:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos,
    output logic          vblank,
    output logic          nmi_pulse,
    output logic          irq
);

    frame_evt_t    evt;
    ctrl_t         ctrl;
    logic [TW-1:0] htgt;
    logic [TW-1:0] vtgt;
    logic          irq_hit;

    raster_counter #(
        .HW(HW), .VW(VW),
        .LINE_LEN(LINE_LEN), .LINE_ADJ(LINE_ADJ),
        .NTSC_SHORT_LINE(NTSC_SHORT_LINE), .PAL_LONG_LINE(PAL_LONG_LINE),
        .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
        .VBL_LINE(VBL_LINE), .VBL_OVS_LINE(VBL_OVS_LINE)
    ) u_counter (
        .clk(clk), .rst(rst), .step(step),
        .pal_mode(pal_mode), .interlace(interlace),
        .even_frame(even_frame), .overscan(overscan),
        .hpos(hpos), .vpos(vpos), .vblank(vblank), .evt(evt)
    );

    raster_irq_cmp #(.HW(HW), .VW(VW), .TW(TW)) u_cmp (
        .clk(clk), .rst(rst), .step(step),
        .hpos(hpos), .vpos(vpos), .ctrl(ctrl),
        .htgt(htgt), .vtgt(vtgt), .hit(irq_hit)
    );

    raster_regs #(
        .HW(HW), .TW(TW), .DW(DW),
        .HBL_START(HBL_START), .HBL_END(HBL_END)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel_e'(wr_sel)), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel_e'(rd_sel)),
        .hpos(hpos), .vblank(vblank), .evt(evt), .irq_hit(irq_hit),
        .ctrl(ctrl), .htgt(htgt), .vtgt(vtgt),
        .nmi_pulse(nmi_pulse), .irq(irq), .rd_data(rd_data)
    );

    // R5: the NMI request lasts a single cycle
    assert_nmi_single_R5: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |=> !nmi_pulse);

endmodule

// File: tb/tb_raster_irq_timer.sv
module tb_raster_irq_timer;

    localparam int LEN   = 64;
    localparam int ADJ   = 4;
    localparam int HBL_S = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b1;
    logic        pal_mode = 1'b0, interlace = 1'b0, even_frame = 1'b0, overscan = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd3;
    logic [7:0]  rd_data;
    logic [10:0] hpos;
    logic [8:0]  vpos;
    logic        vblank, nmi_pulse, irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    raster_irq_timer #(.LINE_LEN(LEN), .LINE_ADJ(ADJ), .HBL_START(HBL_S)) dut (
        .clk(clk), .rst(rst), .step(step),
        .pal_mode(pal_mode), .interlace(interlace),
        .even_frame(even_frame), .overscan(overscan),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .hpos(hpos), .vpos(vpos), .vblank(vblank),
        .nmi_pulse(nmi_pulse), .irq(irq)
    );

    // Fields: pal, il, even, ovs, probe line, expected length, last line, blank line
    localparam logic [41:0] VECS [7] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 9'd240, 11'd60, 9'd261, 9'd225},
        {1'b0, 1'b0, 1'b1, 1'b1, 9'd240, 11'd64, 9'd261, 9'd240},
        {1'b0, 1'b1, 1'b0, 1'b0, 9'd240, 11'd64, 9'd261, 9'd225},
        {1'b0, 1'b1, 1'b1, 1'b0, 9'd100, 11'd64, 9'd262, 9'd225},
        {1'b1, 1'b1, 1'b0, 1'b0, 9'd311, 11'd68, 9'd311, 9'd225},
        {1'b1, 1'b1, 1'b1, 1'b0, 9'd311, 11'd64, 9'd312, 9'd225},
        {1'b1, 1'b0, 1'b0, 1'b1, 9'd311, 11'd64, 9'd311, 9'd240}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        rd_en = 1'b1; rd_sel = sel;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0; rd_sel = 2'd3;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit saw;
        @(negedge clk);

        // Table: line length (R2), last line (R3), blank line (R4), stepping (R1)
        for (int i = 0; i < 7; i++) begin
            int cnt, maxv, vbl_line;
            bit seen_vbl, seen_nz;
            {pal_mode, interlace, even_frame, overscan} = VECS[i][41:38];
            do_reset();
            cnt = 0; maxv = 0; vbl_line = 0; seen_vbl = 0; seen_nz = 0;
            while (!(seen_nz && vpos == 0)) begin
                if (vpos == VECS[i][37:29]) cnt++;
                if (int'(vpos) > maxv) maxv = vpos;
                if (vblank && !seen_vbl) begin seen_vbl = 1; vbl_line = vpos; end
                if (vpos != 0) seen_nz = 1;
                @(negedge clk);
            end
            chk($sformatf("R2 R1 line length vec%0d", i), cnt * 2, VECS[i][28:18]);
            chk($sformatf("R3 last line vec%0d", i), maxv, VECS[i][17:9]);
            chk($sformatf("R4 blank line vec%0d", i), vbl_line, VECS[i][8:0]);
        end
        {pal_mode, interlace, even_frame, overscan} = 4'b0;

        // R10 reset state and R1 stall
        do_reset();
        chk("R10 hpos", hpos, 0);
        chk("R10 vpos", vpos, 0);
        chk("R10 vblank/irq/nmi", {vblank, irq, nmi_pulse}, 0);
        step = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 stalled hpos", hpos, 0);
        step = 1'b1;
        @(negedge clk);
        chk("R1 one step", hpos, 2);

        // R10 H target resets to 0x1FF: unreachable, low byte keeps bit 8
        wr(3'd0, 8'h10);
        saw = 0;
        repeat (100) begin if (irq) saw = 1; @(negedge clk); end
        chk("R10 H target reset unreachable", saw, 0);
        wr(3'd1, 8'd5);
        saw = 0;
        repeat (70) begin if (irq) saw = 1; @(negedge clk); end
        chk("R10 H bit 8 kept", saw, 0);
        wr(3'd2, 8'd0);

        // R7 H-only match at hpos 20
        while (hpos != 20) @(negedge clk);
        chk("R7 not yet on match cycle", irq, 0);
        @(negedge clk);
        chk("R7 H irq rises", {irq, hpos}, {1'b1, 11'd22});
        rd(2'd1, v);
        chk("R8 IRQ read value", v, 8'h80);
        chk("R8 IRQ read acknowledges", irq, 0);
        rd(2'd1, v);
        chk("R8 IRQ read after ack", v, 8'h00);
        while (hpos != 20) @(negedge clk);
        @(negedge clk);
        chk("R7 H irq next line", irq, 1);
        wr(3'd0, 8'h00);
        chk("R8 disable drops irq", irq, 0);

        // R7 V-only edge, no retrigger while held
        do_reset();
        wr(3'd3, 8'd10);
        wr(3'd4, 8'd0);
        wr(3'd0, 8'h20);
        while (vpos != 10) @(negedge clk);
        chk("R7 V not yet", irq, 0);
        @(negedge clk);
        chk("R7 V irq rises", irq, 1);
        rd(2'd1, v);
        saw = 0;
        repeat (20) begin if (irq) saw = 1; @(negedge clk); end
        chk("R7 no retrigger while condition holds", saw, 0);

        // R7 combined H and V
        do_reset();
        wr(3'd1, 8'd5);
        wr(3'd2, 8'd0);
        wr(3'd3, 8'd3);
        wr(3'd4, 8'd0);
        wr(3'd0, 8'h30);
        while (!irq) @(negedge clk);
        chk("R7 H&V position", {vpos, hpos}, {9'd3, 11'd22});

        // R5 NMI pulse, R9 status, R4 line 0 clear
        do_reset();
        wr(3'd0, 8'h80);
        while (vpos != 225) @(negedge clk);
        chk("R5 pulse at blank entry", {nmi_pulse, vblank}, 2'b11);
        @(negedge clk);
        chk("R5 pulse one cycle", nmi_pulse, 0);
        while (hpos != 10) @(negedge clk);
        rd(2'd2, v);
        chk("R9 status mid-line in blank", v, 8'h80);
        while (hpos != HBL_S - 2) @(negedge clk);
        rd(2'd2, v);
        chk("R9 status before hblank", v, 8'h80);
        rd(2'd2, v);
        chk("R9 status at hblank start", v, 8'hC0);
        while (!(vpos == 226 && hpos == 2)) @(negedge clk);
        rd(2'd2, v);
        chk("R9 status hpos 2", v, 8'hC0);
        rd(2'd2, v);
        chk("R9 status hpos 4", v, 8'h80);
        while (vpos != 0) @(negedge clk);
        rd(2'd2, v);
        chk("R9 R4 status at line 0", v, 8'h40);
        rd(2'd0, v);
        chk("R4 line 0 cleared NMI flag", v, 8'h02);

        // R6 re-enable, R5 read clear
        do_reset();
        saw = 0;
        while (vpos != 225) begin if (nmi_pulse) saw = 1; @(negedge clk); end
        chk("R6 no pulse when disabled", saw | nmi_pulse, 0);
        wr(3'd0, 8'h80);
        chk("R6 pulse on re-enable", nmi_pulse, 1);
        rd(2'd0, v);
        chk("R5 NMI flag read", v, 8'h82);
        rd(2'd0, v);
        chk("R5 NMI flag cleared by read", v, 8'h02);
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h80);
        chk("R6 no pulse once flag read", nmi_pulse, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule